// File: doc/BRIEF.md
# Interrupt Source Range Mapper

This block turns the logical interrupt source number raised by an attached accelerator into an index into an interrupt vector table. Software programs four ranges. Each range has a size and its own base offset. Together the ranges cover one contiguous span of source numbers. Range 0 starts at source number 0, and each later range starts where the span of the ranges before it ends. A source number that falls inside range k is rebased to the start of that range and added to base offset k. A source number that lands in no enabled range produces a one-cycle drop pulse instead of a vector.

Two other request kinds share the output. An internal fault request always uses base offset 0, which is the slot of source number 0. An error request skips the mapping altogether and takes its vector from the error-vector input. The 64-bit limit register changes only on a full-width write. On that write, any size above the supported maximum is clamped to the maximum, so software can write all ones and read back the largest size the block supports.

Top module: `irq_range_map`

## Requirements
- R1: After reset, vec_valid_o and drop_o are 0, all four base offsets are 0, and limit_rd_o reads 64'h0001_0000_0000_0000 (range 0 size 1, all other sizes 0).
- R2: Limit register layout: the range 0 size is bits [63:48], range 1 is [47:32], range 2 is [31:16] and range 3 is [15:0]. limit_rd_o returns the stored sizes in this same layout.
- R3: On a full write, a size field above MAX_RANGE (default 16'h0800) is stored as MAX_RANGE, so writing 16'hFFFF reads back 16'h0800. A size field at or below MAX_RANGE is stored unchanged.
- R4: A limit write is accepted only when lim_be_i is 8'hFF. A write with any byte enable low leaves the limit register unchanged.
- R5: A source request with 1 <= N < S0 and S0 != 0 yields vector base0 + N. Base k is set by a write with ofs_we_i=1 and ofs_idx_i=k.
- R6: For k = 1..3, let L_k be the sum of sizes 0..k-1. A source request with L_k <= N < L_k + S_k and S_k != 0 yields base_k + (N - L_k). The ranges are tested in order 0, 1, 2, 3.
- R7: A size-0 range matches no source number. A source request that matches no range, including N = 0 or any N at or beyond the total size, gives drop_o = 1 and vec_valid_o = 0.
- R8: A fault request yields vector base0.
- R9: An error request yields vector err_vec_i.
- R10: When requests arrive in the same cycle, the error request wins over the fault request, and the fault request wins over the source request. The losing requests are discarded and produce no output.
- R11: Each result appears as a single-cycle pulse in the cycle after its request. With no request, vec_valid_o and drop_o stay at 0, and they are never 1 at the same time.
- R12: The vector sum wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| lim_we_i | input | 1 | Limit register write strobe |
| lim_be_i | input | 8 | Byte enables of the limit write |
| lim_wdata_i | input | 64 | Limit write data |
| limit_rd_o | output | 64 | Limit register readback |
| ofs_we_i | input | 1 | Base offset write strobe |
| ofs_idx_i | input | 2 | Base offset being written |
| ofs_wdata_i | input | 16 | Base offset write data |
| err_vec_i | input | 16 | Error vector |
| src_valid_i | input | 1 | Source request valid |
| src_num_i | input | 16 | Logical source number |
| fault_req_i | input | 1 | Fault interrupt request |
| err_req_i | input | 1 | Error interrupt request |
| vec_valid_o | output | 1 | Vector result valid |
| vec_o | output | 16 | Vector table index |
| drop_o | output | 1 | Source request dropped |

## Verification
The bench programs an empty range 1 between populated ranges and checks the source numbers on each side of every range edge. A design that skipped the empty range incorrectly, or compared with <= where < is needed, would map the wrong neighbour or drop a valid number. Source numbers 0, one past the total size and 16'hFFFF must all be dropped; a range 0 that admitted 0 would hand out the reserved fault slot. A write of 16'hFFFF must read back as the maximum, and a partial write must change nothing. Range 3 starts near 16'hFFFF so that its vectors wrap. Simultaneous error, fault and source requests check the arbitration order, because a design with the order reversed would return the wrong vector.

// File: rtl/irq_map_pkg.sv
package irq_map_pkg;
  localparam int NUM_RANGES = 4;
  localparam int FIELD_W    = 16;
  localparam int SUM_W      = FIELD_W + $clog2(NUM_RANGES);
  localparam int LIM_W      = NUM_RANGES * FIELD_W;
  localparam int IDX_W      = $clog2(NUM_RANGES);
  localparam int BE_W       = LIM_W / 8;

  typedef logic [FIELD_W-1:0] field_t;
  typedef logic [NUM_RANGES-1:0][FIELD_W-1:0] field_arr_t;
endpackage

// File: rtl/irq_limit_regs.sv
module irq_limit_regs
  import irq_map_pkg::*;
#(
  parameter logic [FIELD_W-1:0] MAX_RANGE = 16'h0800
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [BE_W-1:0]  lim_be_i,
  input  logic [LIM_W-1:0] lim_wdata_i,
  input  logic             ofs_we_i,
  input  logic [IDX_W-1:0] ofs_idx_i,
  input  field_t           ofs_wdata_i,
  output field_arr_t       size_o,
  output field_arr_t       base_o,
  output logic [LIM_W-1:0] limit_rd_o
);
  field_arr_t size_q, base_q;
  field_arr_t size_d;
  logic       full_wr;

  assign full_wr = lim_we_i && (lim_be_i == {BE_W{1'b1}});

  for (genvar k = 0; k < NUM_RANGES; k++) begin : g_field
    field_t wr_field;
    // range 0 sits in the most significant field
    assign wr_field  = lim_wdata_i[LIM_W-1-k*FIELD_W -: FIELD_W];
    assign size_d[k] = (wr_field > MAX_RANGE) ? MAX_RANGE : wr_field;
    assign limit_rd_o[LIM_W-1-k*FIELD_W -: FIELD_W] = size_q[k];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      size_q    <= '0;
      size_q[0] <= field_t'(1);
      base_q    <= '0;
    end else begin
      if (full_wr) size_q <= size_d;
      if (ofs_we_i) base_q[ofs_idx_i] <= ofs_wdata_i;
    end
  end

  assign size_o = size_q;
  assign base_o = base_q;

  AST_PARTIAL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_we_i && lim_be_i != {BE_W{1'b1}}) |=> $stable(limit_rd_o)); // R4
  AST_SIZE_CAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (size_q[0] <= MAX_RANGE) && (size_q[1] <= MAX_RANGE) &&
    (size_q[2] <= MAX_RANGE) && (size_q[3] <= MAX_RANGE)); // R3
endmodule

// File: rtl/irq_range_decode.sv
module irq_range_decode
  import irq_map_pkg::*;
(
  input  field_arr_t size_i,
  input  field_arr_t base_i,
  input  field_t     src_i,
  output logic       hit_o,
  output field_t     vec_o
);
  logic [SUM_W-1:0]      lo [NUM_RANGES+1];
  logic [NUM_RANGES-1:0] hit;
  field_t                cand [NUM_RANGES];
  logic [SUM_W-1:0]      src_ext;

  assign src_ext = SUM_W'(src_i);
  assign lo[0]   = '0;

  for (genvar k = 0; k < NUM_RANGES; k++) begin : g_rng
    logic [SUM_W-1:0] rel;
    logic             in_win;
    assign lo[k+1] = lo[k] + SUM_W'(size_i[k]);
    assign in_win  = (size_i[k] != '0) && (src_ext >= lo[k]) && (src_ext < lo[k+1]);
    if (k == 0) begin : g_first
      // source 0 is reserved for fault interrupts
      assign hit[k] = in_win && (src_i != '0);
    end else begin : g_rest
      assign hit[k] = in_win;
    end
    assign rel     = src_ext - lo[k];
    assign cand[k] = base_i[k] + rel[FIELD_W-1:0];
  end

  always_comb begin
    hit_o = 1'b0;
    vec_o = '0;
    for (int k = NUM_RANGES - 1; k >= 0; k--) begin
      if (hit[k]) begin
        hit_o = 1'b1;
        vec_o = cand[k];
      end
    end
  end
endmodule

// File: rtl/irq_range_map.sv
module irq_range_map
  import irq_map_pkg::*;
#(
  parameter logic [FIELD_W-1:0] MAX_RANGE = 16'h0800
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lim_we_i,
  input  logic [BE_W-1:0]  lim_be_i,
  input  logic [LIM_W-1:0] lim_wdata_i,
  output logic [LIM_W-1:0] limit_rd_o,
  input  logic             ofs_we_i,
  input  logic [IDX_W-1:0] ofs_idx_i,
  input  logic [FIELD_W-1:0] ofs_wdata_i,
  input  logic [FIELD_W-1:0] err_vec_i,
  input  logic             src_valid_i,
  input  logic [FIELD_W-1:0] src_num_i,
  input  logic             fault_req_i,
  input  logic             err_req_i,
  output logic             vec_valid_o,
  output logic [FIELD_W-1:0] vec_o,
  output logic             drop_o
);
  field_arr_t size, base;
  logic       dec_hit;
  field_t     dec_vec;

  irq_limit_regs #(.MAX_RANGE(MAX_RANGE)) u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .lim_we_i    (lim_we_i),
    .lim_be_i    (lim_be_i),
    .lim_wdata_i (lim_wdata_i),
    .ofs_we_i    (ofs_we_i),
    .ofs_idx_i   (ofs_idx_i),
    .ofs_wdata_i (ofs_wdata_i),
    .size_o      (size),
    .base_o      (base),
    .limit_rd_o  (limit_rd_o)
  );

  irq_range_decode u_dec (
    .size_i (size),
    .base_i (base),
    .src_i  (src_num_i),
    .hit_o  (dec_hit),
    .vec_o  (dec_vec)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vec_valid_o <= 1'b0;
      drop_o      <= 1'b0;
      vec_o       <= '0;
    end else begin
      vec_valid_o <= 1'b0;
      drop_o      <= 1'b0;
      if (err_req_i) begin
        vec_valid_o <= 1'b1;
        vec_o       <= err_vec_i;
      end else if (fault_req_i) begin
        vec_valid_o <= 1'b1;
        vec_o       <= base[0];
      end else if (src_valid_i) begin
        if (dec_hit) begin
          vec_valid_o <= 1'b1;
          vec_o       <= dec_vec;
        end else begin
          drop_o <= 1'b1;
        end
      end
    end
  end

  AST_ERR_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_req_i |=> (vec_valid_o && vec_o == $past(err_vec_i))); // R9
  AST_FAULT_VEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_req_i && !err_req_i) |=> (vec_valid_o && vec_o == $past(base[0]))); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(err_req_i || fault_req_i || src_valid_i) |=> (!vec_valid_o && !drop_o)); // R11
  AST_NO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(vec_valid_o && drop_o)); // R11
  AST_DROP_SRC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drop_o |-> $past(src_valid_i && !err_req_i && !fault_req_i)); // R7
endmodule

// File: tb/irq_range_map_tb.sv
`timescale 1ns/1ps
module irq_range_map_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        lim_we_i = 1'b0;
  logic [7:0]  lim_be_i = '0;
  logic [63:0] lim_wdata_i = '0;
  logic [63:0] limit_rd_o;
  logic        ofs_we_i = 1'b0;
  logic [1:0]  ofs_idx_i = '0;
  logic [15:0] ofs_wdata_i = '0;
  logic [15:0] err_vec_i = '0;
  logic        src_valid_i = 1'b0;
  logic [15:0] src_num_i = '0;
  logic        fault_req_i = 1'b0;
  logic        err_req_i = 1'b0;
  logic        vec_valid_o;
  logic [15:0] vec_o;
  logic        drop_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk_i = ~clk_i;

  irq_range_map u_dut (.*);

  localparam int NV = 11;
  localparam logic [15:0] T_N   [NV] = '{16'd1, 16'd3, 16'd4, 16'd6, 16'd7, 16'd22, 16'd23,
                                         16'h0806, 16'h0807, 16'd0, 16'hFFFF};
  localparam logic        T_DRP [NV] = '{0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1};
  localparam logic [15:0] T_VEC [NV] = '{16'h0101, 16'h0103, 16'h0300, 16'h0302, 16'hFFF0,
                                         16'hFFFF, 16'h0000, 16'h07EF, 16'h0, 16'h0, 16'h0};

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr_lim(input logic [7:0] be, input logic [63:0] d);
    @(negedge clk_i);
    lim_we_i = 1'b1; lim_be_i = be; lim_wdata_i = d;
    @(negedge clk_i);
    lim_we_i = 1'b0; lim_be_i = '0;
  endtask

  task automatic wr_ofs(input logic [1:0] i, input logic [15:0] d);
    @(negedge clk_i);
    ofs_we_i = 1'b1; ofs_idx_i = i; ofs_wdata_i = d;
    @(negedge clk_i);
    ofs_we_i = 1'b0;
  endtask

  // drive at negedge, result registered at next posedge, sample at following negedge
  task automatic req(input logic s, input logic [15:0] n, input logic f, input logic e,
                     input string tag, input logic exp_v, input logic exp_d,
                     input logic [15:0] exp_vec);
    @(negedge clk_i);
    src_valid_i = s; src_num_i = n; fault_req_i = f; err_req_i = e;
    @(negedge clk_i);
    src_valid_i = 1'b0; fault_req_i = 1'b0; err_req_i = 1'b0;
    chk({tag, " valid"}, 64'(vec_valid_o), 64'(exp_v));
    chk({tag, " drop"}, 64'(drop_o), 64'(exp_d));
    if (exp_v) chk({tag, " vec"}, 64'(vec_o), 64'(exp_vec));
    @(negedge clk_i);
    chk({tag, " pulse R11"}, 64'({vec_valid_o, drop_o}), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 valid", 64'(vec_valid_o), 64'(0));
    chk("R1 drop", 64'(drop_o), 64'(0));
    chk("R1 limit", limit_rd_o, 64'h0001_0000_0000_0000);
    rst_ni = 1'b1;
    req(1'b0, 16'd0, 1'b1, 1'b0, "R1 base0 reset R8", 1, 0, 16'h0000);

    // R2/R3 layout and clamp: S0=4 S1=0 S2=3 S3=FFFF->0800
    wr_lim(8'hFF, 64'h0004_0000_0003_FFFF);
    chk("R3 clamp R2 layout", limit_rd_o, 64'h0004_0000_0003_0800);
    // R4 partial write ignored
    wr_lim(8'h7F, 64'h0);
    chk("R4 partial", limit_rd_o, 64'h0004_0000_0003_0800);
    wr_lim(8'h00, 64'h1111_1111_1111_1111);
    chk("R4 no-be", limit_rd_o, 64'h0004_0000_0003_0800);
    // R3 in-range value stored as is
    wr_lim(8'hFF, 64'h0004_0000_0003_0800);
    chk("R3 exact max", limit_rd_o, 64'h0004_0000_0003_0800);

    wr_ofs(2'd0, 16'h0100);
    wr_ofs(2'd1, 16'h0200);
    wr_ofs(2'd2, 16'h0300);
    wr_ofs(2'd3, 16'hFFF0);

    // R5 R6 R7 R12 table walk
    for (int i = 0; i < NV; i++)
      req(1'b1, T_N[i], 1'b0, 1'b0, $sformatf("R5/R6/R7/R12 N=%0h", T_N[i]),
          !T_DRP[i], T_DRP[i], T_VEC[i]);

    // R8 fault, R9 error, R10 priority
    err_vec_i = 16'hABCD;
    req(1'b0, 16'd0, 1'b1, 1'b0, "R8 fault", 1, 0, 16'h0100);
    req(1'b0, 16'd0, 1'b0, 1'b1, "R9 error", 1, 0, 16'hABCD);
    req(1'b1, 16'd3, 1'b1, 1'b1, "R10 all", 1, 0, 16'hABCD);
    req(1'b1, 16'd3, 1'b1, 1'b0, "R10 fault>src", 1, 0, 16'h0100);
    req(1'b1, 16'h0807, 1'b1, 1'b0, "R10 fault beats drop", 1, 0, 16'h0100);

    // R11 idle
    @(negedge clk_i);
    chk("R11 idle", 64'({vec_valid_o, drop_o}), 64'(0));

    // R6 range 1 active, R7 ranges 2/3 disabled: S0=2 S1=5
    wr_lim(8'hFF, 64'h0002_0005_0000_0000);
    req(1'b1, 16'd1, 1'b0, 1'b0, "R5 edge", 1, 0, 16'h0101);
    req(1'b1, 16'd2, 1'b0, 1'b0, "R6 r1 lo", 1, 0, 16'h0200);
    req(1'b1, 16'd6, 1'b0, 1'b0, "R6 r1 hi", 1, 0, 16'h0204);
    req(1'b1, 16'd7, 1'b0, 1'b0, "R7 past end", 0, 1, 16'h0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hang exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule